// File: doc/BRIEF.md
# Paged Memory Mapper with Video Overlay

This block sits between a CPU with a 16-bit address bus and a large paged RAM. It splits the 64 KiB CPU space into eight 8 KiB windows. Each window has its own 8-bit page register, and each memory access becomes a physical page number plus a 13-bit offset. The page registers are loaded through an indexed register file. One I/O port latches a register index and a second I/O port writes the selected register or reads it back.

Older software banks memory in 16 KiB units through three legacy ports. Two of these ports each hold part of a 7-bit bank number. A write to any of the three legacy ports reloads the two top windows with that bank's two 8 KiB halves and puts ROM back into the two bottom windows.

A separate overlay control port can lay the video frame buffer over the bottom of the address space. The frame buffer is three consecutive 16 KiB banks, and the overlay can be enabled for reads only, for writes only, or for both. Address translation is combinational. Register updates take effect on the clock edge that captures the I/O write.

Top module: `mm_mapper`

## Requirements
- R1: After reset the windows hold pages 0xFF, 0xFF, 0x0A, 0x0B, 0x04, 0x05, 0x00, 0x01 for windows 0 to 7, and rom_sel is asserted for any idle access in 0x0000–0x3FFF.
- R2: An I/O write to 0x243B latches the register index. An I/O write to 0x253B then stores the data in the selected register. Window k is register index 0x50+k, and io_rdata always shows the selected register's value.
- R3: With no overlay in effect, phys_page equals the page register of window cpu_addr[15:13] and phys_off equals cpu_addr[12:0].
- R4: A value of 0xFF in window 0 or window 1 selects ROM. rom_sel is then 1 and phys_page is the window number (0 or 1). A value of 0xFF in windows 2 to 7 is an ordinary RAM page.
- R5: Port 0x7FFD supplies data[2:0] and port 0xDFFD supplies data[3:0] of a 7-bit bank n = {DFFD bits, 7FFD bits}. After either write, window 6 holds page 2n and window 7 holds page 2n+1.
- R6: A write to 0x7FFD, 0xDFFD or 0x1FFD sets windows 0 and 1 back to 0xFF (ROM).
- R7: A write to port 0x123B sets the overlay fields from the data bits: bit 0 drives the display enable output l2_disp_en, bit 1 enables the write overlay, bit 2 enables the read overlay, bit 3 picks the shadow base, and bits 7:6 pick the overlay mode. All fields reset to 0.
- R8: The overlay applies only to an access whose direction is enabled (cpu_wr with the write enable, or cpu_rd with the read enable). Every other access, including an idle bus, uses the normal window mapping.
- R9: Overlay modes 0, 1 and 2 map the first, second or third 16 KiB of the frame buffer over 0x0000–0x3FFF. Mode 3 maps all 48 KiB over 0x0000–0xBFFF. The page is 2*(base+third)+cpu_addr[13], taken modulo 256, and rom_sel is 0.
- R10: Register 0x12 holds the active frame-buffer base bank and resets to 9. Register 0x13 holds the shadow base bank and resets to 12. Both can be written and read back.
- R11: Reading back a register index that is not implemented returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU memory address |
| cpu_rd | input | 1 | Memory read strobe |
| cpu_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write cycle, one per clock |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Value of the selected indexed register |
| phys_page | output | 8 | Physical 8 KiB page number |
| phys_off | output | 13 | Offset inside the page |
| rom_sel | output | 1 | Access targets ROM instead of RAM |
| l2_disp_en | output | 1 | Frame buffer display enable |

## Verification
Translation is purely combinational. The bench sets cpu_addr and the strobes, waits a nanosecond, and compares phys_page, phys_off and rom_sel in the same cycle. An I/O write is driven from one falling edge to the next, so it is captured by the rising edge between them. The bench therefore checks readback data, window contents and the display enable at the falling edge that ends the write, which is one register stage after the write. No check samples at or before the capturing edge.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 8;
    localparam int SLOTS   = 8;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int OFF_W   = ADDR_W - SLOT_W;

    localparam logic [15:0] P_SEL    = 16'h243B;
    localparam logic [15:0] P_DATA   = 16'h253B;
    localparam logic [15:0] P_LO     = 16'h7FFD;
    localparam logic [15:0] P_HI     = 16'hDFFD;
    localparam logic [15:0] P_PLUS   = 16'h1FFD;
    localparam logic [15:0] P_OVL    = 16'h123B;

    localparam logic [7:0] IDX_BASE   = 8'h12;
    localparam logic [7:0] IDX_SHADOW = 8'h13;
    localparam logic [7:0] IDX_SLOT0  = 8'h50;

    localparam logic [PAGE_W-1:0] ROM_TAG    = '1;
    localparam logic [PAGE_W-1:0] BASE_RST   = PAGE_W'(9);
    localparam logic [PAGE_W-1:0] SHADOW_RST = PAGE_W'(12);

    localparam logic [SLOTS-1:0][PAGE_W-1:0] SLOT_RST =
        {8'h01, 8'h00, 8'h05, 8'h04, 8'h0B, 8'h0A, 8'hFF, 8'hFF};

    typedef struct packed {
        logic [1:0] mode;
        logic       shadow;
        logic       rd_en;
        logic       wr_en;
        logic       disp;
    } ovl_ctrl_t;

    typedef struct packed {
        logic [7:0]                      sel;
        logic [SLOTS-1:0][PAGE_W-1:0]    slot;
        logic [PAGE_W-1:0]               base;
        logic [PAGE_W-1:0]               shadow;
        logic [2:0]                      bank_lo;
        logic [3:0]                      bank_hi;
        ovl_ctrl_t                       ctrl;
    } mm_state_t;
endpackage

// File: rtl/mm_regs.sv
module mm_regs
    import mm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          io_wr,
    input  logic [15:0]                   io_addr,
    input  logic [7:0]                    io_wdata,
    output logic [SLOTS-1:0][PAGE_W-1:0]  slot_o,
    output logic [PAGE_W-1:0]             base_o,
    output logic [PAGE_W-1:0]             shadow_o,
    output ovl_ctrl_t                     ctrl_o,
    output logic [7:0]                    rdata_o
);
    mm_state_t st_d, st_q;
    logic      legacy_d;
    logic [6:0] bank_d;

    always_comb begin
        st_d     = st_q;
        legacy_d = 1'b0;
        bank_d   = '0;
        if (io_wr) begin
            case (io_addr)
                P_SEL:  st_d.sel = io_wdata;
                P_DATA: begin
                    if (st_q.sel[7:SLOT_W] == IDX_SLOT0[7:SLOT_W])
                        st_d.slot[st_q.sel[SLOT_W-1:0]] = io_wdata;
                    else if (st_q.sel == IDX_BASE)
                        st_d.base = io_wdata;
                    else if (st_q.sel == IDX_SHADOW)
                        st_d.shadow = io_wdata;
                end
                P_LO: begin
                    st_d.bank_lo = io_wdata[2:0];
                    legacy_d     = 1'b1;
                end
                P_HI: begin
                    st_d.bank_hi = io_wdata[3:0];
                    legacy_d     = 1'b1;
                end
                P_PLUS: legacy_d = 1'b1;
                P_OVL: begin
                    st_d.ctrl.mode   = io_wdata[7:6];
                    st_d.ctrl.shadow = io_wdata[3];
                    st_d.ctrl.rd_en  = io_wdata[2];
                    st_d.ctrl.wr_en  = io_wdata[1];
                    st_d.ctrl.disp   = io_wdata[0];
                end
                default: ;
            endcase
        end
        if (legacy_d) begin
            bank_d     = {st_d.bank_hi, st_d.bank_lo};
            st_d.slot[SLOTS-2] = {bank_d, 1'b0};
            st_d.slot[SLOTS-1] = {bank_d, 1'b1};
            st_d.slot[0] = ROM_TAG;
            st_d.slot[1] = ROM_TAG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel     <= '0;
            st_q.slot    <= SLOT_RST;
            st_q.base    <= BASE_RST;
            st_q.shadow  <= SHADOW_RST;
            st_q.bank_lo <= '0;
            st_q.bank_hi <= '0;
            st_q.ctrl    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.sel[7:SLOT_W] == IDX_SLOT0[7:SLOT_W])
            rdata_o = st_q.slot[st_q.sel[SLOT_W-1:0]];
        else if (st_q.sel == IDX_BASE)
            rdata_o = st_q.base;
        else if (st_q.sel == IDX_SHADOW)
            rdata_o = st_q.shadow;
        else
            rdata_o = '0;
    end

    assign slot_o   = st_q.slot;
    assign base_o   = st_q.base;
    assign shadow_o = st_q.shadow;
    assign ctrl_o   = st_q.ctrl;

    // R2
    sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == P_SEL) |=> (st_q.sel == $past(io_wdata)));

    // R6
    legacy_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == P_LO || io_addr == P_HI || io_addr == P_PLUS))
        |=> (st_q.slot[0] == ROM_TAG && st_q.slot[1] == ROM_TAG));

    // R5
    legacy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == P_LO || io_addr == P_HI || io_addr == P_PLUS))
        |=> (st_q.slot[SLOTS-2][0] == 1'b0 &&
             st_q.slot[SLOTS-1] == (st_q.slot[SLOTS-2] | PAGE_W'(1))));
endmodule

// File: rtl/mm_xlate.sv
module mm_xlate
    import mm_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          rd,
    input  logic                          wr,
    input  logic [SLOTS-1:0][PAGE_W-1:0]  slot,
    input  logic [PAGE_W-1:0]             base,
    input  logic [PAGE_W-1:0]             shadow,
    input  ovl_ctrl_t                     ctrl,
    output logic [PAGE_W-1:0]             page,
    output logic [OFF_W-1:0]              off,
    output logic                          rom,
    output logic                          ovl_hit
);
    logic [SLOT_W-1:0] idx;
    logic [1:0]        third;
    logic              in_span;
    logic [PAGE_W-1:0] bsum;
    logic [PAGE_W-1:0] cur;

    always_comb begin
        idx     = addr[ADDR_W-1 -: SLOT_W];
        cur     = slot[idx];
        in_span = (ctrl.mode == 2'b11) ? (addr[ADDR_W-1 -: 2] != 2'b11)
                                       : (addr[ADDR_W-1 -: 2] == 2'b00);
        ovl_hit = in_span && ((wr && ctrl.wr_en) || (rd && ctrl.rd_en));
        third   = (ctrl.mode == 2'b11) ? addr[ADDR_W-1 -: 2] : ctrl.mode;
        bsum    = (ctrl.shadow ? shadow : base) + PAGE_W'(third);
        off     = addr[OFF_W-1:0];
        rom     = 1'b0;
        if (ovl_hit) begin
            page = {bsum[PAGE_W-2:0], addr[OFF_W]};
        end else if (idx < SLOT_W'(2) && cur == ROM_TAG) begin
            rom  = 1'b1;
            page = PAGE_W'(idx);
        end else begin
            page = cur;
        end
    end
endmodule

// File: rtl/mm_mapper.sv
module mm_mapper
    import mm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic [7:0]  phys_page,
    output logic [12:0] phys_off,
    output logic        rom_sel,
    output logic        l2_disp_en
);
    logic [SLOTS-1:0][PAGE_W-1:0] slot_w;
    logic [PAGE_W-1:0]            base_w;
    logic [PAGE_W-1:0]            shadow_w;
    ovl_ctrl_t                    ctrl_w;
    logic                         ovl_hit_w;

    mm_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .slot_o   (slot_w),
        .base_o   (base_w),
        .shadow_o (shadow_w),
        .ctrl_o   (ctrl_w),
        .rdata_o  (io_rdata)
    );

    mm_xlate u_xlate (
        .addr    (cpu_addr),
        .rd      (cpu_rd),
        .wr      (cpu_wr),
        .slot    (slot_w),
        .base    (base_w),
        .shadow  (shadow_w),
        .ctrl    (ctrl_w),
        .page    (phys_page),
        .off     (phys_off),
        .rom     (rom_sel),
        .ovl_hit (ovl_hit_w)
    );

    assign l2_disp_en = ctrl_w.disp;

    // R4
    rom_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (cpu_addr[15:14] == 2'b00));

    // R8
    idle_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr && !rom_sel) |-> (phys_page == slot_w[cpu_addr[15:13]]));

    // R9
    ovl_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_hit_w && ctrl_w.mode != 2'b11) |-> (cpu_addr[15:14] == 2'b00));
endmodule

// File: tb/mm_mapper_bench.sv
module mm_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata, phys_page;
    logic [12:0] phys_off;
    logic        rom_sel, l2_disp_en;

    int vectors = 0, errors = 0, cyc = 0;
    bit done = 0;

    logic [7:0] m_slot [8];
    logic [7:0] m_base, m_shadow;
    logic [2:0] m_lo;
    logic [3:0] m_hi;
    logic [1:0] m_mode;
    logic       m_s, m_r, m_w, m_e;

    always #2 clk = ~clk;

    mm_mapper u_mm_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .phys_page(phys_page), .phys_off(phys_off),
        .rom_sel(rom_sel), .l2_disp_en(l2_disp_en)
    );

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic legacy_model();
        m_slot[6] = {m_hi, m_lo, 1'b0};
        m_slot[7] = {m_hi, m_lo, 1'b1};
        m_slot[0] = 8'hFF;
        m_slot[1] = 8'hFF;
    endtask

    task automatic read_reg(input string req, input logic [7:0] idx, input int exp);
        io_write(16'h243B, idx);
        chk(req, io_rdata, exp);
    endtask

    function automatic logic [8:0] expect_map(input logic [15:0] a, input logic rd, input logic wr);
        logic span, hit;
        logic [1:0] third;
        logic [7:0] b, v;
        logic [2:0] k;
        k = a[15:13];
        span = (m_mode == 2'd3) ? (a < 16'hC000) : (a[15:14] == 2'd0);
        hit = span && ((wr && m_w) || (rd && m_r));
        if (hit) begin
            third = (m_mode == 2'd3) ? a[15:14] : m_mode;
            b = m_s ? m_shadow : m_base;
            return {1'b0, 8'((int'(b) + int'(third)) * 2 + int'(a[13]))};
        end
        v = m_slot[k];
        if (k < 3'd2 && v == 8'hFF) return {1'b1, 5'd0, k};
        return {1'b0, v};
    endfunction

    task automatic sweep(input string req, input int dirs);
        logic [8:0] e;
        for (int a = 0; a < 65536; a += 256 + 37) begin
            for (int d = 0; d < dirs; d++) begin
                cpu_addr = 16'(a);
                cpu_rd = (d == 1);
                cpu_wr = (d == 2);
                #0.5;
                e = expect_map(16'(a), cpu_rd, cpu_wr);
                chk(req, phys_page, e[7:0]);
                chk(req, rom_sel, e[8]);
                chk(req, phys_off, a & 16'h1FFF);
            end
        end
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                done = 1;
                errors++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        m_slot = '{8'hFF, 8'hFF, 8'h0A, 8'h0B, 8'h04, 8'h05, 8'h00, 8'h01};
        m_base = 8'd9; m_shadow = 8'd12; m_lo = 0; m_hi = 0;
        m_mode = 0; m_s = 0; m_r = 0; m_w = 0; m_e = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset windows, R10 reset bases, R7 display off
        for (int k = 0; k < 8; k++) read_reg("R1", 8'(8'h50 + k), m_slot[k]);
        read_reg("R10", 8'h12, 9);
        read_reg("R10", 8'h13, 12);
        chk("R7", l2_disp_en, 0);
        sweep("R1", 1);

        // R2 write windows, R3 translation
        for (int k = 0; k < 8; k++) begin
            m_slot[k] = 8'((k * 37 + 5) & 8'h7F);
            io_write(16'h243B, 8'(8'h50 + k));
            io_write(16'h253B, m_slot[k]);
            chk("R2", io_rdata, m_slot[k]);
        end
        for (int k = 7; k >= 0; k--) read_reg("R2", 8'(8'h50 + k), m_slot[k]);
        sweep("R3", 3);

        // R4 ROM tag only in windows 0 and 1
        for (int k = 0; k < 8; k += 5) begin
            m_slot[k] = 8'hFF;
            io_write(16'h243B, 8'(8'h50 + k));
            io_write(16'h253B, 8'hFF);
        end
        m_slot[1] = 8'hFF;
        io_write(16'h243B, 8'h51);
        io_write(16'h253B, 8'hFF);
        sweep("R4", 3);

        // R5 legacy bank sweep, R6 ROM restore
        for (int n = 0; n < 128; n++) begin
            io_write(16'h243B, 8'h50);
            io_write(16'h253B, 8'h33);
            m_slot[0] = 8'h33;
            m_hi = 4'(n >> 3);
            io_write(16'hDFFD, 8'(n >> 3));
            legacy_model();
            m_lo = 3'(n);
            io_write(16'h7FFD, 8'(n | 8'hF8));
            legacy_model();
            read_reg("R5", 8'h56, m_slot[6]);
            read_reg("R5", 8'h57, m_slot[7]);
            read_reg("R6", 8'h50, 8'hFF);
        end
        io_write(16'h243B, 8'h51);
        io_write(16'h253B, 8'h44);
        m_slot[1] = 8'h44;
        read_reg("R6", 8'h51, 8'h44);
        io_write(16'h1FFD, 8'h00);
        legacy_model();
        read_reg("R6", 8'h51, 8'hFF);
        sweep("R6", 3);

        // R10 base registers
        m_base = 8'd20; m_shadow = 8'd126;
        io_write(16'h243B, 8'h12); io_write(16'h253B, m_base);
        chk("R10", io_rdata, m_base);
        io_write(16'h243B, 8'h13); io_write(16'h253B, m_shadow);
        chk("R10", io_rdata, m_shadow);

        // R7 R8 R9 overlay configurations
        for (int c = 0; c < 64; c++) begin
            m_e = c[0]; m_w = c[1]; m_r = c[2]; m_s = c[3]; m_mode = 2'(c >> 4);
            io_write(16'h123B, {m_mode, 2'b11, m_s, m_r, m_w, m_e});
            chk("R7", l2_disp_en, m_e);
            sweep((m_r || m_w) ? "R9" : "R8", 3);
        end

        // R11 unimplemented indices
        read_reg("R11", 8'h00, 0);
        read_reg("R11", 8'h58, 0);
        read_reg("R11", 8'h4F, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule